// File: doc/BRIEF.md
# ECC Error Capture Unit

This block watches the read side of a 64-bit ECC-protected memory path. On every beat it receives the returned data, the stored check bits, the beat address, and two error indications from an external SEC-DED decoder. A multi-bit error raises a sticky flag at once. Single-bit errors are counted, and their flag is raised only when the count reaches a programmable threshold. The first flagged error freezes a snapshot of its data, check bits and address. That snapshot stays in place until software clears the flags.

A word-indexed register port gives software access to the flags, the per-class detect masks, the interrupt enables, the threshold and counter, the snapshot, and three injection registers. On the write path, the injection masks can flip chosen data bits and check bits. Software can then plant known faults and exercise the whole reporting chain. The error-correcting arithmetic and the memory protocol belong to other blocks.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset every register reads zero and `irq` is low. Register word indices are: 0 flags, 1 detect mask, 2 interrupt enable, 3 single-bit management, 4 snapshot data 63:32, 5 snapshot data 31:0, 6 snapshot check bits, 7 snapshot address 31:0, 8 snapshot address upper bits, 9 data injection 63:32, 10 data injection 31:0, 11 injection control. Any other index reads zero.
- R2: A beat with `mon_valid` high and `mon_mbe` high sets flag bit 1 (multi-bit) on the next clock edge. A beat with `mon_valid` low changes nothing. A set flag stays set until it is cleared.
- R3: Writing the flag register clears each flag whose write-data bit is one and leaves the others alone, so writing all ones clears everything. When a flag is set and cleared in the same cycle, the set wins.
- R4: Detect mask bit 0 suppresses single-bit counting and flagging, and bit 1 suppresses multi-bit flagging. A mask of zero leaves all detection enabled.
- R5: Management bits 7:0 hold a single-bit counter and bits 23:16 hold the threshold. Each counted single-bit beat increments the counter. When the incremented value reaches the threshold, flag bit 0 sets and the counter returns to zero. A threshold of 0 acts as 1, and writing 0x10000 gives a threshold of one. A register write loads both fields.
- R6: A beat that asserts both `mon_sbe` and `mon_mbe` is treated as multi-bit only and leaves the single-bit counter unchanged.
- R7: When a flag sets while no flag is pending, the snapshot registers load that beat's data, check bits and address. The address is split into bits 31:0 and the upper bits. While any flag is pending, the snapshot is held. Single-bit beats that stay below the threshold never load it.
- R8: `irq` is high exactly while the bitwise AND of the flags and the interrupt enable is nonzero. Bit 0 covers single-bit errors and bit 1 covers multi-bit errors.
- R9: The injection registers read back what was written. Injection control bits 7:0 are the check-bit mask and bit 8 is the enable. While enabled, `wr_data_out` is `wr_data_in` XOR {index 9, index 10} and `wr_check_out` is `wr_check_in` XOR the mask. While disabled, both pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 4 | Register word index for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_idx) |
| mon_valid | input | 1 | Read beat strobe |
| mon_data | input | 64 | Beat data |
| mon_check | input | 8 | Beat stored check bits |
| mon_addr | input | PADDR_W (40) | Beat address |
| mon_sbe | input | 1 | Decoder reports a single-bit error |
| mon_mbe | input | 1 | Decoder reports a multi-bit error |
| wr_data_in | input | 64 | Write-path data before injection |
| wr_check_in | input | 8 | Write-path check bits before injection |
| wr_data_out | output | 64 | Write-path data after injection |
| wr_check_out | output | 8 | Write-path check bits after injection |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default 40-bit address. The upper snapshot register is therefore 8 bits wide, and the bench checks the split of one address across both snapshot registers. The default 8-bit counter and threshold let the bench use thresholds of 0, 1 and 3, and observe a partial count before the flag fires. Other scenarios cover simultaneous set and clear, both error lines on one beat, masking, and snapshot freezing under a second error. Injection is tested with the enable bit off and on, with the same masks in place.

// File: rtl/ecc_cap_pkg.sv
// Package: shared register indices, field positions and widths for the
// ECC error capture unit. Assumes a 4-bit word index register port.
package ecc_cap_pkg;

    localparam int REG_AW     = 4;
    localparam int REG_W      = 32;
    localparam int CHK_W      = 8;
    localparam int CNT_W      = 8;
    localparam int FLAG_W     = 2;
    localparam int FLAG_SBE   = 0;
    localparam int FLAG_MBE   = 1;
    localparam int THR_LSB    = 16;
    localparam int INJ_EN_BIT = 8;

    typedef enum logic [REG_AW-1:0] {
        IDX_FLAGS   = 4'd0,
        IDX_MASK    = 4'd1,
        IDX_IEN     = 4'd2,
        IDX_MGMT    = 4'd3,
        IDX_CAP_HI  = 4'd4,
        IDX_CAP_LO  = 4'd5,
        IDX_CAP_CHK = 4'd6,
        IDX_CAP_AL  = 4'd7,
        IDX_CAP_AH  = 4'd8,
        IDX_INJ_HI  = 4'd9,
        IDX_INJ_LO  = 4'd10,
        IDX_INJ_CTL = 4'd11
    } reg_idx_e;

endpackage

// File: rtl/ecc_cap_sbe_counter.sv
// Module: single-bit error counter with threshold.
// Counts qualified single-bit beats. Reports "reach" in the cycle where the
// incremented count meets the threshold, then returns to zero. A threshold
// of zero behaves like one. A software load overrides counting.
module ecc_cap_sbe_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic [CNT_W-1:0] thresh,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             reach
);

    logic [CNT_W:0] cnt_inc;

    // Incremented count, one bit wider so it cannot wrap
    always_comb begin
        cnt_inc = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
        reach   = hit && (cnt_inc >= {1'b0, thresh});
    end

    // Counter register: load, count or clear on threshold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (hit) begin
            cnt <= reach ? '0 : cnt_inc[CNT_W-1:0];
        end
    end

    // R5: threshold hit clears the counter
    a_r5_clear_on_reach: assert property (@(posedge clk) disable iff (!rst_n)
        (reach && !load) |=> (cnt == '0));

    // R5: below threshold the counter steps by one
    a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !reach && !load) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/ecc_cap_inject.sv
// Module: write-path fault injection.
// XORs the data and check-bit masks into the outgoing write when enabled,
// otherwise passes the write through. Purely combinational.
module ecc_cap_inject #(
    parameter int DATA_W = 64,
    parameter int CHK_W  = 8
) (
    input  logic              inj_en,
    input  logic [DATA_W-1:0] data_mask,
    input  logic [CHK_W-1:0]  check_mask,
    input  logic [DATA_W-1:0] data_in,
    input  logic [CHK_W-1:0]  check_in,
    output logic [DATA_W-1:0] data_out,
    output logic [CHK_W-1:0]  check_out
);

    // Gated XOR of both masks
    always_comb begin
        data_out  = data_in  ^ (inj_en ? data_mask  : '0);
        check_out = check_in ^ (inj_en ? check_mask : '0);
    end

endmodule

// File: rtl/ecc_cap_regs.sv
// Module: register file of the capture unit.
// Holds the sticky flags, detect mask, interrupt enable, threshold, snapshot
// and injection registers, and drives the read mux. Assumes PADDR_W is in
// 33..63 and that set events come already qualified by the mask.
module ecc_cap_regs
    import ecc_cap_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int PADDR_W = 40
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [REG_AW-1:0]   idx,
    input  logic [REG_W-1:0]    wdata,
    output logic [REG_W-1:0]    rdata,
    input  logic                sbe_set,
    input  logic                mbe_set,
    input  logic [DATA_W-1:0]   beat_data,
    input  logic [CHK_W-1:0]    beat_check,
    input  logic [PADDR_W-1:0]  beat_addr,
    input  logic [CNT_W-1:0]    cnt,
    output logic [FLAG_W-1:0]   flags,
    output logic [FLAG_W-1:0]   mask,
    output logic [FLAG_W-1:0]   ien,
    output logic [CNT_W-1:0]    thresh,
    output logic                mgmt_load,
    output logic                inj_en,
    output logic [DATA_W-1:0]   inj_data,
    output logic [CHK_W-1:0]    inj_check
);

    localparam int HALF_W = DATA_W / 2;
    localparam int EXT_W  = PADDR_W - 32;

    logic [FLAG_W-1:0]  flag_clr;
    logic [FLAG_W-1:0]  flag_nxt;
    logic               cap_en;
    logic [HALF_W-1:0]  cap_hi;
    logic [HALF_W-1:0]  cap_lo;
    logic [CHK_W-1:0]   cap_chk;
    logic [31:0]        cap_al;
    logic [EXT_W-1:0]   cap_ah;
    logic [HALF_W-1:0]  inj_hi;
    logic [HALF_W-1:0]  inj_lo;
    logic [INJ_EN_BIT:0] inj_ctl;

    // Decode write-one-to-clear, set-wins flag update and snapshot enable
    always_comb begin
        flag_clr  = (wr_en && idx == IDX_FLAGS) ? wdata[FLAG_W-1:0] : '0;
        flag_nxt  = (flags & ~flag_clr);
        flag_nxt[FLAG_SBE] = flag_nxt[FLAG_SBE] | sbe_set;
        flag_nxt[FLAG_MBE] = flag_nxt[FLAG_MBE] | mbe_set;
        cap_en    = (flags == '0) && (sbe_set || mbe_set);
        mgmt_load = wr_en && (idx == IDX_MGMT);
    end

    // Sticky flag register
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= flag_nxt;
    end

    // Software-owned control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask    <= '0;
            ien     <= '0;
            thresh  <= '0;
            inj_hi  <= '0;
            inj_lo  <= '0;
            inj_ctl <= '0;
        end else if (wr_en) begin
            case (idx)
                IDX_MASK:    mask    <= wdata[FLAG_W-1:0];
                IDX_IEN:     ien     <= wdata[FLAG_W-1:0];
                IDX_MGMT:    thresh  <= wdata[THR_LSB +: CNT_W];
                IDX_INJ_HI:  inj_hi  <= wdata[HALF_W-1:0];
                IDX_INJ_LO:  inj_lo  <= wdata[HALF_W-1:0];
                IDX_INJ_CTL: inj_ctl <= wdata[INJ_EN_BIT:0];
                default: ;
            endcase
        end
    end

    // Snapshot of the first flagged beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_hi  <= '0;
            cap_lo  <= '0;
            cap_chk <= '0;
            cap_al  <= '0;
            cap_ah  <= '0;
        end else if (cap_en) begin
            cap_hi  <= beat_data[DATA_W-1:HALF_W];
            cap_lo  <= beat_data[HALF_W-1:0];
            cap_chk <= beat_check;
            cap_al  <= beat_addr[31:0];
            cap_ah  <= beat_addr[PADDR_W-1:32];
        end
    end

    // Injection outputs toward the write path
    always_comb begin
        inj_en    = inj_ctl[INJ_EN_BIT];
        inj_data  = {inj_hi, inj_lo};
        inj_check = inj_ctl[CHK_W-1:0];
    end

    // Read mux, unmapped indices read zero
    always_comb begin
        rdata = '0;
        case (idx)
            IDX_FLAGS:   rdata[FLAG_W-1:0] = flags;
            IDX_MASK:    rdata[FLAG_W-1:0] = mask;
            IDX_IEN:     rdata[FLAG_W-1:0] = ien;
            IDX_MGMT: begin
                rdata[THR_LSB +: CNT_W] = thresh;
                rdata[CNT_W-1:0]        = cnt;
            end
            IDX_CAP_HI:  rdata[HALF_W-1:0]     = cap_hi;
            IDX_CAP_LO:  rdata[HALF_W-1:0]     = cap_lo;
            IDX_CAP_CHK: rdata[CHK_W-1:0]      = cap_chk;
            IDX_CAP_AL:  rdata                 = cap_al;
            IDX_CAP_AH:  rdata[EXT_W-1:0]      = cap_ah;
            IDX_INJ_HI:  rdata[HALF_W-1:0]     = inj_hi;
            IDX_INJ_LO:  rdata[HALF_W-1:0]     = inj_lo;
            IDX_INJ_CTL: rdata[INJ_EN_BIT:0]   = inj_ctl;
            default:     rdata = '0;
        endcase
    end

    // R2: a multi-bit flag survives unless its bit is written with one
    a_r2_mbe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[FLAG_MBE] && !(wr_en && idx == IDX_FLAGS && wdata[FLAG_MBE]))
        |=> flags[FLAG_MBE]);

    // R3: a set event wins over a same-cycle clear
    a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        mbe_set |=> flags[FLAG_MBE]);

    // R7: snapshot frozen while any flag is pending
    a_r7_snapshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (flags != '0) |=> ($stable(cap_hi) && $stable(cap_lo) &&
                           $stable(cap_chk) && $stable(cap_al) && $stable(cap_ah)));

endmodule

// File: rtl/ecc_err_capture.sv
// Module: ECC error capture unit, top level.
// Qualifies decoder error indications by the detect mask, counts single-bit
// errors against a threshold, keeps flags and a snapshot, drives a level
// interrupt and applies write-path fault injection. Assumes the decoder
// never needs both error lines counted separately: multi-bit takes priority.
module ecc_err_capture
    import ecc_cap_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int PADDR_W = 40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [REG_AW-1:0]  reg_idx,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic               mon_valid,
    input  logic [DATA_W-1:0]  mon_data,
    input  logic [CHK_W-1:0]   mon_check,
    input  logic [PADDR_W-1:0] mon_addr,
    input  logic               mon_sbe,
    input  logic               mon_mbe,
    input  logic [DATA_W-1:0]  wr_data_in,
    input  logic [CHK_W-1:0]   wr_check_in,
    output logic [DATA_W-1:0]  wr_data_out,
    output logic [CHK_W-1:0]   wr_check_out,
    output logic               irq
);

    logic [FLAG_W-1:0] flags;
    logic [FLAG_W-1:0] mask;
    logic [FLAG_W-1:0] ien;
    logic [CNT_W-1:0]  thresh;
    logic [CNT_W-1:0]  cnt;
    logic              mgmt_load;
    logic              sbe_hit;
    logic              sbe_reach;
    logic              mbe_hit;
    logic              inj_en;
    logic [DATA_W-1:0] inj_data;
    logic [CHK_W-1:0]  inj_check;

    // Qualify beat events: valid strobe, mask, multi-bit priority
    always_comb begin
        mbe_hit = mon_valid && mon_mbe && !mask[FLAG_MBE];
        sbe_hit = mon_valid && mon_sbe && !mon_mbe && !mask[FLAG_SBE];
    end

    ecc_cap_sbe_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (sbe_hit),
        .thresh   (thresh),
        .load     (mgmt_load),
        .load_val (reg_wdata[CNT_W-1:0]),
        .cnt      (cnt),
        .reach    (sbe_reach)
    );

    ecc_cap_regs #(.DATA_W(DATA_W), .PADDR_W(PADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_we),
        .idx        (reg_idx),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .sbe_set    (sbe_reach),
        .mbe_set    (mbe_hit),
        .beat_data  (mon_data),
        .beat_check (mon_check),
        .beat_addr  (mon_addr),
        .cnt        (cnt),
        .flags      (flags),
        .mask       (mask),
        .ien        (ien),
        .thresh     (thresh),
        .mgmt_load  (mgmt_load),
        .inj_en     (inj_en),
        .inj_data   (inj_data),
        .inj_check  (inj_check)
    );

    ecc_cap_inject #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_inj (
        .inj_en     (inj_en),
        .data_mask  (inj_data),
        .check_mask (inj_check),
        .data_in    (wr_data_in),
        .check_in   (wr_check_in),
        .data_out   (wr_data_out),
        .check_out  (wr_check_out)
    );

    // Level interrupt from enabled pending flags
    always_comb irq = |(flags & ien);

    // R4: a multi-bit flag only rises after an unmasked multi-bit beat
    a_r4_mbe_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FLAG_MBE]) |-> $past(mon_valid && mon_mbe && !mask[FLAG_MBE]));

    // R6: a beat with both error lines leaves the counter alone
    a_r6_mbe_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_valid && mon_sbe && mon_mbe && !mgmt_load) |=> $stable(cnt));

    // R8: enabled multi-bit beat raises the interrupt next cycle
    a_r8_irq_mbe: assert property (@(posedge clk) disable iff (!rst_n)
        (mbe_hit && ien[FLAG_MBE] && !(reg_we && reg_idx == IDX_IEN)) |=> irq);

    // R9: disabled injection passes the write through
    a_r9_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        !inj_en |-> (wr_data_out == wr_data_in && wr_check_out == wr_check_in));

endmodule

// File: tb/ecc_err_capture_tb_top.sv
`timescale 1ns/1ps
module ecc_err_capture_tb_top;

    localparam int PADDR_W = 40;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               reg_we = 1'b0;
    logic [3:0]         reg_idx = '0;
    logic [31:0]        reg_wdata = '0;
    logic [31:0]        reg_rdata;
    logic               mon_valid = 1'b0;
    logic [63:0]        mon_data = '0;
    logic [7:0]         mon_check = '0;
    logic [PADDR_W-1:0] mon_addr = '0;
    logic               mon_sbe = 1'b0;
    logic               mon_mbe = 1'b0;
    logic [63:0]        wr_data_in = '0;
    logic [7:0]         wr_check_in = '0;
    logic [63:0]        wr_data_out;
    logic [7:0]         wr_check_out;
    logic               irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    ecc_err_capture #(.DATA_W(64), .PADDR_W(PADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mon_valid(mon_valid),
        .mon_data(mon_data), .mon_check(mon_check), .mon_addr(mon_addr),
        .mon_sbe(mon_sbe), .mon_mbe(mon_mbe), .wr_data_in(wr_data_in),
        .wr_check_in(wr_check_in), .wr_data_out(wr_data_out),
        .wr_check_out(wr_check_out), .irq(irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [3:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_idx = idx; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [3:0] idx, output logic [31:0] d);
        @(negedge clk);
        reg_idx = idx;
        #1 d = reg_rdata;
    endtask

    task automatic rd_check(input string req, input logic [3:0] idx, input logic [31:0] exp);
        logic [31:0] d;
        reg_rd(idx, d);
        check(req, {32'b0, d}, {32'b0, exp});
    endtask

    task automatic beat(input logic v, input logic s, input logic m,
                        input logic [63:0] d, input logic [7:0] c,
                        input logic [PADDR_W-1:0] a);
        @(negedge clk);
        mon_valid = v; mon_sbe = s; mon_mbe = m;
        mon_data = d; mon_check = c; mon_addr = a;
        @(posedge clk);
        @(negedge clk);
        mon_valid = 1'b0; mon_sbe = 1'b0; mon_mbe = 1'b0;
    endtask

    task automatic t_reset();
        for (int i = 0; i < 12; i++) rd_check("R1 reset reg", 4'(i), 32'h0);
        rd_check("R1 unmapped", 4'd14, 32'h0);
        check("R1 irq", {63'b0, irq}, 64'h0);
    endtask

    task automatic t_mbe();
        beat(1'b0, 1'b0, 1'b1, 64'h1111_2222_3333_4444, 8'h55, 40'h12_0000_0040);
        rd_check("R2 invalid beat ignored", 4'd0, 32'h0);
        beat(1'b1, 1'b0, 1'b1, 64'hDEAD_BEEF_0123_4567, 8'hA5, 40'hAB_CDEF_0120);
        rd_check("R2 mbe flag", 4'd0, 32'h2);
        rd_check("R7 cap hi", 4'd4, 32'hDEAD_BEEF);
        rd_check("R7 cap lo", 4'd5, 32'h0123_4567);
        rd_check("R7 cap chk", 4'd6, 32'hA5);
        rd_check("R7 cap addr lo", 4'd7, 32'hCDEF_0120);
        rd_check("R7 cap addr hi", 4'd8, 32'hAB);
        check("R8 irq off when disabled", {63'b0, irq}, 64'h0);
        reg_wr(4'd2, 32'h2);
        check("R8 irq on", {63'b0, irq}, 64'h1);
        beat(1'b1, 1'b0, 1'b1, 64'h0, 8'h00, 40'h0);
        rd_check("R7 snapshot held", 4'd4, 32'hDEAD_BEEF);
        reg_wr(4'd0, 32'h1);
        rd_check("R3 other bit kept", 4'd0, 32'h2);
        reg_wr(4'd0, 32'h2);
        rd_check("R3 cleared", 4'd0, 32'h0);
        check("R8 irq drops", {63'b0, irq}, 64'h0);
    endtask

    task automatic t_threshold();
        reg_wr(4'd3, 32'h0003_0000);
        beat(1'b1, 1'b1, 1'b0, 64'h1, 8'h01, 40'h1);
        beat(1'b1, 1'b1, 1'b0, 64'h2, 8'h02, 40'h2);
        rd_check("R5 partial count", 4'd3, 32'h0003_0002);
        rd_check("R5 no flag yet", 4'd0, 32'h0);
        rd_check("R7 no capture below threshold", 4'd5, 32'h0123_4567);
        beat(1'b1, 1'b1, 1'b0, 64'h0000_0007_0000_0003, 8'h03, 40'h05_0000_0003);
        rd_check("R5 flag at threshold", 4'd0, 32'h1);
        rd_check("R5 count cleared", 4'd3, 32'h0003_0000);
        rd_check("R7 sbe capture lo", 4'd5, 32'h3);
        rd_check("R7 sbe capture hi", 4'd4, 32'h7);
        rd_check("R7 sbe addr hi", 4'd8, 32'h05);
        check("R8 sbe irq masked", {63'b0, irq}, 64'h0);
        reg_wr(4'd2, 32'h3);
        check("R8 sbe irq", {63'b0, irq}, 64'h1);
        reg_wr(4'd0, 32'hFFFF_FFFF);
        rd_check("R3 all ones clear", 4'd0, 32'h0);
    endtask

    task automatic t_threshold_low();
        reg_wr(4'd3, 32'h0001_0000);
        beat(1'b1, 1'b1, 1'b0, 64'h9, 8'h09, 40'h9);
        rd_check("R5 threshold one", 4'd0, 32'h1);
        reg_wr(4'd0, 32'h1);
        reg_wr(4'd3, 32'h0);
        beat(1'b1, 1'b1, 1'b0, 64'hA, 8'h0A, 40'hA);
        rd_check("R5 threshold zero", 4'd0, 32'h1);
        rd_check("R5 threshold zero count", 4'd3, 32'h0);
        reg_wr(4'd0, 32'h3);
    endtask

    task automatic t_mask();
        reg_wr(4'd3, 32'h0001_0000);
        reg_wr(4'd1, 32'h3);
        beat(1'b1, 1'b1, 1'b0, 64'h1, 8'h1, 40'h1);
        beat(1'b1, 1'b0, 1'b1, 64'h1, 8'h1, 40'h1);
        rd_check("R4 masked flags", 4'd0, 32'h0);
        rd_check("R4 masked count", 4'd3, 32'h0001_0000);
        reg_wr(4'd1, 32'h1);
        beat(1'b1, 1'b0, 1'b1, 64'h1, 8'h1, 40'h1);
        rd_check("R4 mbe unmasked", 4'd0, 32'h2);
        reg_wr(4'd0, 32'h3);
        reg_wr(4'd1, 32'h0);
    endtask

    task automatic t_priority();
        reg_wr(4'd3, 32'h0005_0000);
        beat(1'b1, 1'b1, 1'b1, 64'h4, 8'h4, 40'h4);
        rd_check("R6 mbe only", 4'd0, 32'h2);
        rd_check("R6 count untouched", 4'd3, 32'h0005_0000);
        reg_wr(4'd0, 32'h3);
    endtask

    task automatic t_set_wins();
        @(negedge clk);
        reg_we = 1'b1; reg_idx = 4'd0; reg_wdata = 32'hFFFF_FFFF;
        mon_valid = 1'b1; mon_mbe = 1'b1; mon_data = 64'h5; mon_addr = 40'h5;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0; mon_valid = 1'b0; mon_mbe = 1'b0;
        rd_check("R3 set wins", 4'd0, 32'h2);
        reg_wr(4'd0, 32'h2);
    endtask

    task automatic t_inject();
        reg_wr(4'd9,  32'h8000_0001);
        reg_wr(4'd10, 32'h0000_F000);
        reg_wr(4'd11, 32'h0000_0081);
        rd_check("R9 inj hi readback", 4'd9, 32'h8000_0001);
        rd_check("R9 inj lo readback", 4'd10, 32'h0000_F000);
        rd_check("R9 inj ctl readback", 4'd11, 32'h81);
        @(negedge clk);
        wr_data_in = 64'h0123_4567_89AB_CDEF; wr_check_in = 8'h3C;
        #1;
        check("R9 passthru data", wr_data_out, 64'h0123_4567_89AB_CDEF);
        check("R9 passthru check", {56'b0, wr_check_out}, 64'h3C);
        reg_wr(4'd11, 32'h0000_0181);
        #1;
        check("R9 injected data", wr_data_out, 64'h0123_4567_89AB_CDEF ^ 64'h8000_0001_0000_F000);
        check("R9 injected check", {56'b0, wr_check_out}, {56'b0, 8'h3C ^ 8'h81});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mbe();
        t_threshold();
        t_threshold_low();
        t_mask();
        t_priority();
        t_set_wins();
        t_inject();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule